// File: doc/BRIEF.md
# Configurable UART Frame Receiver

This block recovers asynchronous serial characters from a single input line. The frame format is chosen at run time: a 20-bit integer divider gives the bit period in system clocks, a two-bit length code picks 5 to 8 data bits, a parity enable and a parity sense select none, even or odd, and a two-bit stop code picks one, one and a half or two stop bits. An inversion flag flips the line before anything else looks at it, so an idle-low line can be received directly.

A falling edge on the synchronized line is a start candidate. It becomes a frame only if the line is still low half a bit period later. Every following bit is sampled once, at its middle. When the first stop bit is sampled, the assembled word comes out on a one-cycle valid strobe, together with one-cycle parity-error and frame-error pulses. If the stop bit was low and the line is still low when the stop span ends, a break pulse is raised. The receiver then waits for the line to go high before it looks for a new start bit. The settings must be held steady while a frame is in progress.

Top module: `uart_frame_rx`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `rxValid`, `parityErr`, `frameErr` and `breakDet` are low.
- R2: A low pulse on the line that ends before half a bit period (`bitPeriod >> 1` clocks, at least 1) produces no output strobe.
- R3: Data bits arrive least significant first. `wordCode` 0, 1, 2 and 3 select 5, 6, 7 and 8 bits, and the unused upper bits of `rxData` read 0.
- R4: With `parityOn` = 1, the bit after the data is parity: `parityOdd` = 0 means the count of ones over data plus parity is even, 1 means it is odd. A mismatch pulses `parityErr` in the same cycle as `rxValid`, and the word is still delivered. With `parityOn` = 0, `parityErr` stays low.
- R5: A low level at the middle of the first stop bit pulses `frameErr` in the same cycle as `rxValid`.
- R6: If the stop bit was low and the line is still low when the stop span ends, `breakDet` pulses for one cycle. No further frame is started until the line has returned high.
- R7: `stopCode` 2 gives a stop span of one and a half bit periods and 3 gives two. Both 1 and 0 give one bit. Frames sent back to back with the matching stop length are each received.
- R8: With `invertIn` = 1, the line is complemented before start detection and sampling.
- R9: Every strobe is high for exactly one cycle, and `rxValid` rises once per accepted frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serialIn | input | 1 | Serial line, idle high before inversion |
| invertIn | input | 1 | Complement the line before use |
| bitPeriod | input | 20 | Bit period in clocks (values below 2 act as 2) |
| wordCode | input | 2 | Data length: 0..3 give 5..8 bits |
| parityOn | input | 1 | Expect and check a parity bit |
| parityOdd | input | 1 | 0 even, 1 odd parity |
| stopCode | input | 2 | 0/1 one, 2 one and a half, 3 two stop bits |
| rxData | output | 8 | Last received word, zero-extended |
| rxValid | output | 1 | One-cycle strobe for a new word |
| parityErr | output | 1 | One-cycle parity mismatch pulse |
| frameErr | output | 1 | One-cycle low-stop-bit pulse |
| breakDet | output | 1 | One-cycle break pulse |

## Verification
Clean frames are sent at every word length, with both parity senses and several divider values, including an odd one. These tell apart errors in bit order, word masking and mid-bit timing. Corrupted parity bits separate the even and odd checks and confirm that the word is still delivered. A short low glitch and a low stop bit that recovers within the stop span keep apart start qualification, frame error and break. A long low level covers break detection and the wait for the line to return high. Back-to-back frames at each stop setting, and a run with the inversion flag set, expose a wrong stop-span length and a wrong line polarity.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  localparam int WORD_MAX = 8;
  localparam int IDX_W    = $clog2(WORD_MAX);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP,
    ST_TAIL,
    ST_HOLD
  } rxState_e;

  // which interval the shared bit timer measures
  typedef enum logic [1:0] {
    SPAN_HALF,
    SPAN_FULL,
    SPAN_TAIL
  } span_e;

  typedef struct packed {
    logic  countOn;
    span_e span;
    logic  beginFrame;
    logic  takeData;
    logic  takeParity;
    logic  closeFrame;
    logic  raiseBreak;
  } rxStrobe_t;

  function automatic logic [3:0] wordBits(input logic [1:0] code);
    return 4'(code) + 4'd5;
  endfunction

endpackage

// File: rtl/uart_rx_datapath.sv
module uart_rx_datapath
  import uart_rx_pkg::*;
#(
  parameter int DIV_W       = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                serialIn,
  input  logic                invertIn,
  input  logic [DIV_W-1:0]    bitPeriod,
  input  logic [1:0]          wordCode,
  input  logic                parityOn,
  input  logic                parityOdd,
  input  logic [1:0]          stopCode,
  input  rxStrobe_t           strb,
  output logic                tick,
  output logic                lineLow,
  output logic                lastBit,
  output logic                stopWasBad,
  output logic [WORD_MAX-1:0] rxData,
  output logic                rxValid,
  output logic                parityErr,
  output logic                frameErr,
  output logic                breakDet
);

  localparam int CNT_W = DIV_W + 1;

  // line conditioning: inversion first, then synchronizer
  logic lineIn;
  assign lineIn = serialIn ^ invertIn;

  generate
    if (SYNC_STAGES >= 2) begin : g_sync
      logic [SYNC_STAGES-1:0] syncQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], lineIn};
      end
      assign lineLow = ~syncQ[SYNC_STAGES-1];
    end else begin : g_single
      logic syncQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= 1'b1;
        else       syncQ <= lineIn;
      end
      assign lineLow = ~syncQ;
    end
  endgenerate

  // bit timer
  logic [CNT_W-1:0] periodEff, halfP, tailP, target, cnt;

  always_comb begin
    periodEff = (bitPeriod < DIV_W'(2)) ? CNT_W'(2) : {1'b0, bitPeriod};
    halfP     = periodEff >> 1;
    unique case (stopCode)
      2'd2:    tailP = periodEff;
      2'd3:    tailP = periodEff + halfP;
      default: tailP = halfP;
    endcase
    unique case (strb.span)
      SPAN_HALF: target = halfP;
      SPAN_TAIL: target = tailP;
      default:   target = periodEff;
    endcase
  end

  assign tick = strb.countOn && (cnt == target - CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     cnt <= '0;
    else if (!strb.countOn || tick) cnt <= '0;
    else                           cnt <= cnt + CNT_W'(1);
  end

  // word assembly
  logic [IDX_W-1:0]    bitIdx;
  logic [WORD_MAX-1:0] word;
  logic                parityBit;
  logic [3:0]          nBits;

  assign nBits   = wordBits(wordCode);
  assign lastBit = (4'(bitIdx) == nBits - 4'd1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitIdx    <= '0;
      word      <= '0;
      parityBit <= 1'b0;
    end else if (strb.beginFrame) begin
      bitIdx    <= '0;
      word      <= '0;
      parityBit <= 1'b0;
    end else begin
      if (strb.takeData) begin
        word[bitIdx] <= ~lineLow;
        bitIdx       <= bitIdx + IDX_W'(1);
      end
      if (strb.takeParity) parityBit <= ~lineLow;
    end
  end

  // result registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData     <= '0;
      rxValid    <= 1'b0;
      parityErr  <= 1'b0;
      frameErr   <= 1'b0;
      breakDet   <= 1'b0;
      stopWasBad <= 1'b0;
    end else begin
      rxValid   <= strb.closeFrame;
      parityErr <= strb.closeFrame && parityOn && ((^word) ^ parityBit ^ parityOdd);
      frameErr  <= strb.closeFrame && lineLow;
      breakDet  <= strb.raiseBreak;
      if (strb.closeFrame) begin
        rxData     <= word;
        stopWasBad <= lineLow;
      end
    end
  end

  assert_valid_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  assert_break_apart_R6: assert property (@(posedge clk) disable iff (!rstN)
    breakDet |-> !rxValid);

  assert_perr_with_valid_R4: assert property (@(posedge clk) disable iff (!rstN)
    parityErr |-> rxValid);

  assert_ferr_with_valid_R5: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |-> rxValid);

endmodule

// File: rtl/uart_rx_control.sv
module uart_rx_control
  import uart_rx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      tick,
  input  logic      lineLow,
  input  logic      lastBit,
  input  logic      stopWasBad,
  input  logic      parityOn,
  output rxStrobe_t strb
);

  rxState_e state, nextState;

  always_comb begin
    nextState = state;
    strb      = '0;
    strb.span = SPAN_FULL;
    unique case (state)
      ST_IDLE: begin
        if (lineLow) nextState = ST_START;
      end
      ST_START: begin
        strb.countOn = 1'b1;
        strb.span    = SPAN_HALF;
        if (tick) begin
          if (lineLow) begin
            strb.beginFrame = 1'b1;
            nextState       = ST_DATA;
          end else begin
            nextState = ST_IDLE;
          end
        end
      end
      ST_DATA: begin
        strb.countOn = 1'b1;
        if (tick) begin
          strb.takeData = 1'b1;
          if (lastBit) nextState = parityOn ? ST_PARITY : ST_STOP;
        end
      end
      ST_PARITY: begin
        strb.countOn = 1'b1;
        if (tick) begin
          strb.takeParity = 1'b1;
          nextState       = ST_STOP;
        end
      end
      ST_STOP: begin
        strb.countOn = 1'b1;
        if (tick) begin
          strb.closeFrame = 1'b1;
          nextState       = ST_TAIL;
        end
      end
      ST_TAIL: begin
        strb.countOn = 1'b1;
        strb.span    = SPAN_TAIL;
        if (tick) begin
          if (stopWasBad && lineLow) begin
            strb.raiseBreak = 1'b1;
            nextState       = ST_HOLD;
          end else begin
            nextState = ST_IDLE;
          end
        end
      end
      ST_HOLD: begin
        if (!lineLow) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assert_start_held_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DATA && $past(state) == ST_START) |-> $past(lineLow));

  assert_hold_until_high_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD && lineLow) |=> (state == ST_HOLD));

  assert_break_needs_bad_stop_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.raiseBreak |-> (stopWasBad && lineLow));

  assert_one_action_R9: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strb.beginFrame, strb.takeData, strb.takeParity,
                strb.closeFrame, strb.raiseBreak}) <= 1);

endmodule

// File: rtl/uart_frame_rx.sv
module uart_frame_rx
  import uart_rx_pkg::*;
#(
  parameter int DIV_W       = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             serialIn,
  input  logic             invertIn,
  input  logic [DIV_W-1:0] bitPeriod,
  input  logic [1:0]       wordCode,
  input  logic             parityOn,
  input  logic             parityOdd,
  input  logic [1:0]       stopCode,
  output logic [7:0]       rxData,
  output logic             rxValid,
  output logic             parityErr,
  output logic             frameErr,
  output logic             breakDet
);

  rxStrobe_t strb;
  logic      tick, lineLow, lastBit, stopWasBad;

  uart_rx_control i_control (
    .clk        (clk),
    .rstN       (rstN),
    .tick       (tick),
    .lineLow    (lineLow),
    .lastBit    (lastBit),
    .stopWasBad (stopWasBad),
    .parityOn   (parityOn),
    .strb       (strb)
  );

  uart_rx_datapath #(
    .DIV_W       (DIV_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .serialIn   (serialIn),
    .invertIn   (invertIn),
    .bitPeriod  (bitPeriod),
    .wordCode   (wordCode),
    .parityOn   (parityOn),
    .parityOdd  (parityOdd),
    .stopCode   (stopCode),
    .strb       (strb),
    .tick       (tick),
    .lineLow    (lineLow),
    .lastBit    (lastBit),
    .stopWasBad (stopWasBad),
    .rxData     (rxData),
    .rxValid    (rxValid),
    .parityErr  (parityErr),
    .frameErr   (frameErr),
    .breakDet   (breakDet)
  );

endmodule

// File: tb/test_uart_frame_rx.sv
module test_uart_frame_rx;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        serialIn = 1'b1;
  logic        invertIn = 1'b0;
  logic [19:0] bitPeriod = 20'd16;
  logic [1:0]  wordCode = 2'd3;
  logic        parityOn = 1'b0;
  logic        parityOdd = 1'b0;
  logic [1:0]  stopCode = 2'd1;
  logic [7:0]  rxData;
  logic        rxValid, parityErr, frameErr, breakDet;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  uart_frame_rx i_uart_frame_rx (
    .clk(clk), .rstN(rstN), .serialIn(serialIn), .invertIn(invertIn),
    .bitPeriod(bitPeriod), .wordCode(wordCode), .parityOn(parityOn),
    .parityOdd(parityOdd), .stopCode(stopCode), .rxData(rxData),
    .rxValid(rxValid), .parityErr(parityErr), .frameErr(frameErr),
    .breakDet(breakDet)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference: a phase number and a countdown of clocks
  int  mPhase = 0, mLeft = 0, mIdx = 0, mWord = 0, mPar = 0;
  int  mOld1 = 1, mOld2 = 1;
  bit  mBad = 0;
  bit  eValid = 0, ePerr = 0, eFerr = 0, eBrk = 0;
  int  eData = 0;

  function automatic int periodOf();
    return (bitPeriod < 2) ? 2 : int'(bitPeriod);
  endfunction

  always @(posedge clk) begin
    int p, h, line;
    p = periodOf();
    h = p / 2;
    line = mOld2;
    eValid = 0; ePerr = 0; eFerr = 0; eBrk = 0;
    if (!rstN) begin
      mPhase = 0; mLeft = 0; mOld1 = 1; mOld2 = 1; mBad = 0; eData = 0;
    end else begin
      if (mPhase == 0) begin
        if (line == 0) begin mPhase = 1; mLeft = h; end
      end else if (mPhase == 6) begin
        if (line == 1) mPhase = 0;
      end else begin
        mLeft--;
        if (mLeft == 0) begin
          case (mPhase)
            1: if (line == 0) begin mPhase = 2; mLeft = p; mIdx = 0; mWord = 0; mPar = 0; end
               else mPhase = 0;
            2: begin
                 mWord = mWord | (line << mIdx);
                 mIdx++;
                 mLeft = p;
                 if (mIdx == int'(wordCode) + 5) mPhase = parityOn ? 3 : 4;
               end
            3: begin mPar = line; mLeft = p; mPhase = 4; end
            4: begin
                 eValid = 1;
                 eData = mWord;
                 ePerr = parityOn && (($countones(mWord) + mPar + int'(parityOdd)) % 2 == 1);
                 eFerr = (line == 0);
                 mBad = eFerr;
                 mLeft = (stopCode == 2) ? p : (stopCode == 3) ? p + h : h;
                 mPhase = 5;
               end
            5: begin
                 if (mBad && line == 0) begin eBrk = 1; mPhase = 6; end
                 else mPhase = 0;
               end
            default: mPhase = 0;
          endcase
        end
      end
      mOld2 = mOld1;
      mOld1 = int'(serialIn ^ invertIn);
    end
  end

  // per-cycle comparison and event monitor
  int frameCnt = 0, perrCnt = 0, ferrCnt = 0, brkCnt = 0;
  int lastData = 0;
  int gotData[$];

  always @(negedge clk) begin
    if (rstN && !done) begin
      check(rxValid === eValid, "R9 rxValid vs model", int'(rxValid), int'(eValid));
      check(parityErr === ePerr, "R4 parityErr vs model", int'(parityErr), int'(ePerr));
      check(frameErr === eFerr, "R5 frameErr vs model", int'(frameErr), int'(eFerr));
      check(breakDet === eBrk, "R6 breakDet vs model", int'(breakDet), int'(eBrk));
      if (eValid)
        check(rxData === 8'(eData), "R3 rxData vs model", int'(rxData), eData);
      if (rxValid) begin frameCnt++; lastData = int'(rxData); gotData.push_back(int'(rxData)); end
      if (parityErr) perrCnt++;
      if (frameErr) ferrCnt++;
      if (breakDet) brkCnt++;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic drive(input bit level, input int n);
    serialIn = level ^ invertIn;
    repeat (n) @(negedge clk);
  endtask

  task automatic sendFrame(input int d, input bit badPar, input bit badStop);
    int p, nb, ones, units, stopLen;
    p = periodOf();
    nb = int'(wordCode) + 5;
    ones = 0;
    drive(0, p);
    for (int i = 0; i < nb; i++) begin
      drive(d[i], p);
      ones += d[i];
    end
    if (parityOn) drive(1'((ones + int'(parityOdd) + int'(badPar)) % 2), p);
    units = (stopCode == 2) ? 3 : (stopCode == 3) ? 4 : 2;
    stopLen = (units * p + 1) / 2;
    if (badStop) begin
      drive(0, (3 * p) / 4);
      drive(1, stopLen - (3 * p) / 4);
    end else begin
      drive(1, stopLen);
    end
  endtask

  task automatic settle();
    drive(1, 3 * periodOf());
  endtask

  task automatic setFormat(input int bp, input int wc, input bit po, input bit odd, input int sc);
    bitPeriod = 20'(bp);
    wordCode = 2'(wc);
    parityOn = po;
    parityOdd = odd;
    stopCode = 2'(sc);
  endtask

  initial begin
    int f0, pe0, fe0, bk0;
    repeat (3) @(negedge clk);
    // R1: quiet during reset
    check({rxValid, parityErr, frameErr, breakDet} === 4'b0, "R1 strobes in reset",
          int'({rxValid, parityErr, frameErr, breakDet}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check({rxValid, parityErr, frameErr, breakDet} === 4'b0, "R1 strobes after reset",
          int'({rxValid, parityErr, frameErr, breakDet}), 0);
    settle();

    // R3: 8 data bits, no parity
    setFormat(16, 3, 0, 0, 1);
    f0 = frameCnt;
    sendFrame(8'hA5, 0, 0); settle();
    check(frameCnt == f0 + 1, "R3 one frame 8N1", frameCnt - f0, 1);
    check(lastData == 8'hA5, "R3 data 8N1", lastData, 8'hA5);

    // R3: long divider, LSB-first order visible
    setFormat(40, 3, 0, 0, 1);
    sendFrame(8'h01, 0, 0); settle();
    check(lastData == 8'h01, "R3 lsb first", lastData, 8'h01);

    // R3 R4: 5 bits, even parity, upper bits zero-extended
    setFormat(16, 0, 1, 0, 1);
    pe0 = perrCnt;
    sendFrame(8'hF3, 0, 0); settle();
    check(lastData == 8'h13, "R3 five-bit zero extend", lastData, 8'h13);
    check(perrCnt == pe0, "R4 even parity clean", perrCnt - pe0, 0);

    // R4: 6 bits odd parity, wrong parity bit, word still delivered
    setFormat(15, 1, 1, 1, 1);
    f0 = frameCnt; pe0 = perrCnt;
    sendFrame(8'h2C, 1, 0); settle();
    check(frameCnt == f0 + 1, "R4 word delivered on error", frameCnt - f0, 1);
    check(lastData == 8'h2C, "R4 data on error", lastData, 8'h2C);
    check(perrCnt == pe0 + 1, "R4 odd parity error", perrCnt - pe0, 1);

    // R4: 7 bits even parity, wrong bit
    setFormat(16, 2, 1, 0, 1);
    pe0 = perrCnt;
    sendFrame(8'h55, 1, 0); settle();
    check(perrCnt == pe0 + 1, "R4 even parity error", perrCnt - pe0, 1);
    check(lastData == 8'h55, "R3 seven-bit data", lastData, 8'h55);

    // R4: 6 bits odd parity, correct bit
    setFormat(16, 1, 1, 1, 1);
    pe0 = perrCnt;
    sendFrame(8'h07, 0, 0); settle();
    check(perrCnt == pe0, "R4 odd parity clean", perrCnt - pe0, 0);

    // R2: short glitch
    setFormat(16, 3, 0, 0, 1);
    f0 = frameCnt;
    drive(0, 3); settle();
    check(frameCnt == f0, "R2 glitch rejected", frameCnt - f0, 0);

    // R5: low stop bit that recovers, no break
    f0 = frameCnt; fe0 = ferrCnt; bk0 = brkCnt;
    sendFrame(8'h3C, 0, 1); settle();
    check(ferrCnt == fe0 + 1, "R5 frame error", ferrCnt - fe0, 1);
    check(brkCnt == bk0, "R6 no break on recovery", brkCnt - bk0, 0);
    check(lastData == 8'h3C, "R5 data with frame error", lastData, 8'h3C);

    // R6: long low level
    f0 = frameCnt; bk0 = brkCnt;
    drive(0, 16 * 12);
    check(frameCnt == f0 + 1, "R6 single frame during break", frameCnt - f0, 1);
    check(brkCnt == bk0 + 1, "R6 break pulse", brkCnt - bk0, 1);
    check(lastData == 0, "R6 break data", lastData, 0);
    settle();
    check(frameCnt == f0 + 1, "R6 no frame after break", frameCnt - f0, 1);

    // R8: inverted line
    invertIn = 1'b1;
    serialIn = 1'b0;
    settle();
    f0 = frameCnt;
    sendFrame(8'h5A, 0, 0); settle();
    check(frameCnt == f0 + 1 && lastData == 8'h5A, "R8 inverted frame", lastData, 8'h5A);
    invertIn = 1'b0;
    serialIn = 1'b1;
    settle();

    // R7: back-to-back at each stop setting
    setFormat(16, 3, 0, 0, 2);
    gotData.delete();
    sendFrame(8'h81, 0, 0); sendFrame(8'h7E, 0, 0); settle();
    check(gotData.size() == 2, "R7 one-and-half stop count", gotData.size(), 2);
    if (gotData.size() == 2)
      check(gotData[1] == 8'h7E, "R7 one-and-half second", gotData[1], 8'h7E);

    setFormat(15, 3, 1, 0, 3);
    gotData.delete();
    sendFrame(8'h33, 0, 0); sendFrame(8'hCC, 0, 0); settle();
    check(gotData.size() == 2, "R7 two stop count", gotData.size(), 2);
    if (gotData.size() == 2)
      check(gotData[1] == 8'hCC, "R7 two stop second", gotData[1], 8'hCC);

    setFormat(16, 3, 0, 0, 0);
    gotData.delete(); fe0 = ferrCnt;
    sendFrame(8'h11, 0, 0); sendFrame(8'h22, 0, 0); sendFrame(8'h44, 0, 0); settle();
    check(gotData.size() == 3, "R7 code zero count", gotData.size(), 3);
    check(ferrCnt == fe0, "R7 code zero no frame error", ferrCnt - fe0, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule